// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a byte-wide boot-block flash memory. It reads the stream of bus write cycles. Each write carries a 20-bit address and an 8-bit data byte. The block recognises the coded unlock-and-command sequences for these operations:

- returning to array reads
- entering the identifier (autoselect) mode
- programming a byte
- erasing single blocks or the whole chip
- suspending an erase and resuming it

It reports the current mode and raises one-cycle request pulses for a program/erase engine. It holds the set of blocks chosen for erase. It also returns identifier data for reads made while the identifier mode is active.

The array and the program/erase timing engine live outside this block. The engine reports completion through the single `eng_done` input. Blocks are uniform, and the block index is the address bits at and above `BLK_SHIFT`.

The write port is a valid/ready stream. `wr_ready` rises one cycle after reset is released and then stays high, so the block never applies back-pressure. A write counts only in a cycle where `wr_valid` and `wr_ready` are both high.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (array read), `erase_set` is empty, every request pulse is low, `rd_data` is 00h and `wr_ready` is high.
- R2: On coded cycles only address bits 14..0 are compared: 5555h for the first unlock and command writes, and 2AAAh for the second unlock. Bits 19..15 are ignored.
- R3: Two ways return the block to array read (`mode` 0) from the identifier mode. One is a single F0h write at any address. The other is the three-write form: unlock, unlock, then F0h at 5555h.
- R4: In the identifier mode (`mode` 1), `rd_data` depends on `rd_addr[1:0]`. The value 00 gives 20h, 01 gives the `DEV_CODE` parameter, 10 gives `{7'b0, prot_map[rd_addr[19:16]]}`, and 11 gives 00h. In every other mode `rd_data` is 00h.
- R5: Unlock, unlock, then A0h at 5555h arms a program. The next write raises `prog_req` for exactly one cycle, carrying that write's address and data. `mode` then becomes 2 and every write is ignored until `eng_done`.
- R6: The erase sequence is unlock, unlock, 80h at 5555h, unlock, unlock, then 10h at 5555h. It pulses `chip_erase_req`, sets every bit of `erase_set` and enters `mode` 4 (erase running).
- R7: If the sixth erase write is instead 30h at any address, that block's bit is set and `mode` becomes 3, with `erase_win_open` high. `blk_erase_start` pulses and `mode` becomes 4 exactly `ERASE_TIMEOUT` cycles after the clock edge that accepted the last 30h write.
- R8: While `mode` is 3, each further 30h write adds its block and restarts the timeout. Any other data byte abandons the erase: `mode` returns to 0 and `erase_set` is cleared.
- R9: In `mode` 4, a write of B0h at any address pulses `suspend_req` and enters `mode` 5 (suspended). In `mode` 5, a single 30h write at any address pulses `resume_req` and returns to `mode` 4.
- R10: While suspended, a program to a block outside `erase_set` is accepted and enters `mode` 6. There `eng_done` returns the block to `mode` 5. A program to a block inside `erase_set` raises no pulse and leaves `mode` at 5.
- R11: A write that does not match the expected step of a sequence abandons it. The mode falls back to 0, or stays at 5 when suspended.
- R12: `eng_done` ends modes 2 and 4 in `mode` 0. Ending mode 4 also clears `erase_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Bus write present |
| wr_ready | output | 1 | Write accepted (high whenever out of reset) |
| wr_addr | input | 20 | Write address |
| wr_data | input | 8 | Write data byte |
| eng_done | input | 1 | Program/erase engine finished its operation |
| prot_map | input | 16 | Per-block protection status |
| rd_addr | input | 20 | Read address used in the identifier mode |
| rd_data | output | 8 | Identifier read data |
| mode | output | 3 | 0 read, 1 ident, 2 program, 3 erase window, 4 erase run, 5 suspended, 6 program in suspend |
| erase_win_open | output | 1 | Block-erase address window still open |
| erase_set | output | 16 | One bit per block selected for erase |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | 20 | Program target address |
| prog_data | output | 8 | Program data byte |
| chip_erase_req | output | 1 | One-cycle chip erase request |
| blk_erase_start | output | 1 | One-cycle pulse when the block-erase window closes |
| suspend_req | output | 1 | One-cycle erase suspend request |
| resume_req | output | 1 | One-cycle erase resume request |

## Verification
The assertions assume that `wr_addr` and `wr_data` are known whenever `wr_valid` is high. They also assume that `eng_done` is a single-cycle pulse that never coincides with a write, and that `ERASE_TIMEOUT` is at least one. The stimulus presents each write for exactly one cycle at a falling edge and pulses `eng_done` only after the matching request, in a cycle with no write. Gaps between 30h writes stay shorter than the timeout, except where the bench deliberately lets the window close.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    M_READ    = 3'd0,
    M_IDENT   = 3'd1,
    M_PROG    = 3'd2,
    M_EWIN    = 3'd3,
    M_ERUN    = 3'd4,
    M_SUSP    = 3'd5,
    M_SPROG   = 3'd6
  } mode_t;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_CMD, S_PARG, S_EUNL1, S_EUNL2, S_ECMD
  } step_t;

  localparam logic [14:0] CODED_A = 15'h5555;
  localparam logic [14:0] CODED_B = 15'h2AAA;
  localparam logic [7:0]  D_UNL1  = 8'hAA;
  localparam logic [7:0]  D_UNL2  = 8'h55;
  localparam logic [7:0]  D_RESET = 8'hF0;
  localparam logic [7:0]  D_IDENT = 8'h90;
  localparam logic [7:0]  D_PROG  = 8'hA0;
  localparam logic [7:0]  D_ESET  = 8'h80;
  localparam logic [7:0]  D_CHIP  = 8'h10;
  localparam logic [7:0]  D_BLK   = 8'h30;
  localparam logic [7:0]  D_SUSP  = 8'hB0;
endpackage

// File: rtl/fcd_erase_win.sv
module fcd_erase_win
  import fcd_pkg::*;
#(
  parameter int NBLK    = 16,
  parameter int TIMEOUT = 1000,
  localparam int BW     = $clog2(NBLK),
  localparam int TW     = $clog2(TIMEOUT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_window,
  input  logic            set_blk_v,
  input  logic [BW-1:0]   set_blk_idx,
  input  logic            set_all,
  input  logic            clr,
  input  logic            tmr_load,
  output logic            expire,
  output logic [NBLK-1:0] erase_set
);
  localparam logic [TW-1:0] TMR_FULL = TW'(TIMEOUT);
  localparam logic [TW-1:0] TMR_ONE  = TW'(1);

  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          erase_set <= '0;
    else if (clr)        erase_set <= '0;
    else if (set_all)    erase_set <= '1;
    else if (set_blk_v)  erase_set[set_blk_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          tmr_q <= '0;
    else if (tmr_load)                   tmr_q <= TMR_FULL;
    else if (in_window && tmr_q != '0)   tmr_q <= tmr_q - TMR_ONE;
  end

  assign expire = in_window && !tmr_load && (tmr_q == TMR_ONE);

  assert_window_timer_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |-> (tmr_q != '0));
  assert_window_has_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |-> (erase_set != '0));
endmodule

// File: rtl/fcd_ident.sv
module fcd_ident #(
  parameter int AW             = 20,
  parameter int BLK_SHIFT      = 16,
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'hD2,
  localparam int NBLK          = 1 << (AW - BLK_SHIFT)
) (
  input  logic            ident_active,
  input  logic [AW-1:0]   rd_addr,
  input  logic [NBLK-1:0] prot_map,
  output logic [7:0]      rd_data
);
  logic unused_rd_mid;
  assign unused_rd_mid = ^rd_addr[BLK_SHIFT-1:2];

  always_comb begin
    rd_data = 8'h00;
    if (ident_active) begin
      unique case (rd_addr[1:0])
        2'b00:   rd_data = MFR_CODE;
        2'b01:   rd_data = DEV_CODE;
        2'b10:   rd_data = {7'b0, prot_map[rd_addr[AW-1:BLK_SHIFT]]};
        default: rd_data = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int AW        = 20,
  parameter int BLK_SHIFT = 16,
  localparam int BW       = AW - BLK_SHIFT,
  localparam int NBLK     = 1 << BW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_fire,
  input  logic [AW-1:0]   wr_addr,
  input  logic [7:0]      wr_data,
  input  logic            eng_done,
  input  logic            expire,
  input  logic [NBLK-1:0] erase_set,
  output mode_t           mode_q,
  output logic            prog_req,
  output logic [AW-1:0]   prog_addr,
  output logic [7:0]      prog_data,
  output logic            chip_req,
  output logic            start_req,
  output logic            susp_req,
  output logic            res_req,
  output logic            set_blk_v,
  output logic [BW-1:0]   set_blk_idx,
  output logic            set_all,
  output logic            clr,
  output logic            tmr_load
);
  step_t step_q, ns;
  mode_t nm, home;
  logic  a_prog, a_chip, a_start, a_susp, a_res;
  logic  hit_a, hit_b, susp;

  assign hit_a       = (wr_addr[14:0] == CODED_A);
  assign hit_b       = (wr_addr[14:0] == CODED_B);
  assign set_blk_idx = wr_addr[AW-1:BLK_SHIFT];
  assign susp        = (mode_q == M_SUSP);
  assign home        = susp ? M_SUSP : M_READ;

  always_comb begin
    nm = mode_q; ns = step_q;
    a_prog = 1'b0; a_chip = 1'b0; a_start = 1'b0; a_susp = 1'b0; a_res = 1'b0;
    set_blk_v = 1'b0; set_all = 1'b0; clr = 1'b0; tmr_load = 1'b0;
    unique case (mode_q)
      M_PROG:  if (eng_done) nm = M_READ;
      M_SPROG: if (eng_done) nm = M_SUSP;
      M_ERUN: begin
        if (eng_done) begin
          nm = M_READ; clr = 1'b1;
        end else if (wr_fire && wr_data == D_SUSP) begin
          nm = M_SUSP; a_susp = 1'b1; ns = S_IDLE;
        end
      end
      M_EWIN: begin
        if (wr_fire) begin
          if (wr_data == D_BLK) begin
            set_blk_v = 1'b1; tmr_load = 1'b1;
          end else begin
            nm = M_READ; clr = 1'b1;
          end
        end else if (expire) begin
          nm = M_ERUN; a_start = 1'b1;
        end
      end
      default: begin
        if (wr_fire) begin
          ns = S_IDLE;
          unique case (step_q)
            S_IDLE: begin
              if (hit_a && wr_data == D_UNL1)      ns = S_UNL1;
              else if (susp && wr_data == D_BLK) begin
                nm = M_ERUN; a_res = 1'b1;
              end else                              nm = home;
            end
            S_UNL1: begin
              if (hit_b && wr_data == D_UNL2) ns = S_CMD;
              else                            nm = home;
            end
            S_CMD: begin
              if (!hit_a) nm = home;
              else begin
                unique case (wr_data)
                  D_IDENT: nm = susp ? M_SUSP : M_IDENT;
                  D_PROG:  ns = S_PARG;
                  D_ESET:  if (!susp) ns = S_EUNL1; else nm = home;
                  default: nm = home;
                endcase
              end
            end
            S_PARG: begin
              if (susp && erase_set[set_blk_idx]) nm = M_SUSP;
              else begin
                a_prog = 1'b1;
                nm = susp ? M_SPROG : M_PROG;
              end
            end
            S_EUNL1: begin
              if (hit_a && wr_data == D_UNL1) ns = S_EUNL2;
              else                            nm = home;
            end
            S_EUNL2: begin
              if (hit_b && wr_data == D_UNL2) ns = S_ECMD;
              else                            nm = home;
            end
            default: begin
              if (hit_a && wr_data == D_CHIP) begin
                a_chip = 1'b1; set_all = 1'b1; nm = M_ERUN;
              end else if (wr_data == D_BLK) begin
                set_blk_v = 1'b1; tmr_load = 1'b1; nm = M_EWIN;
              end else nm = home;
            end
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_READ; step_q <= S_IDLE;
      prog_req <= 1'b0; chip_req <= 1'b0; start_req <= 1'b0;
      susp_req <= 1'b0; res_req <= 1'b0;
      prog_addr <= '0; prog_data <= '0;
    end else begin
      mode_q <= nm; step_q <= ns;
      prog_req <= a_prog; chip_req <= a_chip; start_req <= a_start;
      susp_req <= a_susp; res_req <= a_res;
      if (a_prog) begin
        prog_addr <= wr_addr; prog_data <= wr_data;
      end
    end
  end

  assert_single_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, chip_req, start_req, susp_req, res_req}));
  assert_prog_outside_erase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> !erase_set[prog_addr[AW-1:BLK_SHIFT]]);
  assert_chip_sets_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chip_req |-> (&erase_set && mode_q == M_ERUN));
  assert_start_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> (erase_set != '0 && mode_q == M_ERUN));
  assert_suspend_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    susp_req |-> (mode_q == M_SUSP && erase_set != '0));
  assert_resume_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_req |-> mode_q == M_ERUN);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int AW               = 20,
  parameter int BLK_SHIFT        = 16,
  parameter int ERASE_TIMEOUT    = 1000,
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'hD2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_valid,
  output logic                               wr_ready,
  input  logic [AW-1:0]                      wr_addr,
  input  logic [7:0]                         wr_data,
  input  logic                               eng_done,
  input  logic [(1<<(AW-BLK_SHIFT))-1:0]     prot_map,
  input  logic [AW-1:0]                      rd_addr,
  output logic [7:0]                         rd_data,
  output logic [2:0]                         mode,
  output logic                               erase_win_open,
  output logic [(1<<(AW-BLK_SHIFT))-1:0]     erase_set,
  output logic                               prog_req,
  output logic [AW-1:0]                      prog_addr,
  output logic [7:0]                         prog_data,
  output logic                               chip_erase_req,
  output logic                               blk_erase_start,
  output logic                               suspend_req,
  output logic                               resume_req
);
  localparam int BW   = AW - BLK_SHIFT;
  localparam int NBLK = 1 << BW;

  mode_t          mode_q;
  logic           ready_q, wr_fire, expire;
  logic           set_blk_v, set_all, clr, tmr_load;
  logic [BW-1:0]  set_blk_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign wr_ready       = ready_q;
  assign wr_fire        = wr_valid && ready_q;
  assign mode           = mode_q;
  assign erase_win_open = (mode_q == M_EWIN);

  fcd_seq #(.AW(AW), .BLK_SHIFT(BLK_SHIFT)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wr_data(wr_data), .eng_done(eng_done), .expire(expire),
    .erase_set(erase_set), .mode_q(mode_q), .prog_req(prog_req),
    .prog_addr(prog_addr), .prog_data(prog_data), .chip_req(chip_erase_req),
    .start_req(blk_erase_start), .susp_req(suspend_req), .res_req(resume_req),
    .set_blk_v(set_blk_v), .set_blk_idx(set_blk_idx), .set_all(set_all),
    .clr(clr), .tmr_load(tmr_load)
  );

  fcd_erase_win #(.NBLK(NBLK), .TIMEOUT(ERASE_TIMEOUT)) u_win (
    .clk(clk), .rst_n(rst_n), .in_window(erase_win_open),
    .set_blk_v(set_blk_v), .set_blk_idx(set_blk_idx), .set_all(set_all),
    .clr(clr), .tmr_load(tmr_load), .expire(expire), .erase_set(erase_set)
  );

  fcd_ident #(.AW(AW), .BLK_SHIFT(BLK_SHIFT), .MFR_CODE(MFR_CODE),
              .DEV_CODE(DEV_CODE)) u_ident (
    .ident_active(mode_q == M_IDENT), .rd_addr(rd_addr),
    .prot_map(prot_map), .rd_data(rd_data)
  );

  assert_busy_ignores_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PROG && !eng_done) |=> (mode_q == M_PROG && $stable(erase_set)));
  assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> wr_ready);
endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int TO = 8;
  localparam logic [2:0] MD_READ = 3'd0, MD_IDENT = 3'd1, MD_PROG = 3'd2,
                         MD_EWIN = 3'd3, MD_ERUN = 3'd4, MD_SUSP = 3'd5,
                         MD_SPROG = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [19:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        eng_done = 1'b0;
  logic [15:0] prot_map = 16'h0008;
  logic [19:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic [2:0]  mode;
  logic        erase_win_open;
  logic [15:0] erase_set;
  logic        prog_req;
  logic [19:0] prog_addr;
  logic [7:0]  prog_data;
  logic        chip_erase_req, blk_erase_start, suspend_req, resume_req;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder #(.ERASE_TIMEOUT(TO), .DEV_CODE(8'hD2)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .eng_done(eng_done),
    .prot_map(prot_map), .rd_addr(rd_addr), .rd_data(rd_data), .mode(mode),
    .erase_win_open(erase_win_open), .erase_set(erase_set),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .chip_erase_req(chip_erase_req), .blk_erase_start(blk_erase_start),
    .suspend_req(suspend_req), .resume_req(resume_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic unlock();
    wr(20'h05555, 8'hAA);
    wr(20'h02AAA, 8'h55);
  endtask

  task automatic done_pulse();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 mode", mode, MD_READ);
    check("R1 erase_set", erase_set, 0);
    check("R1 ready", wr_ready, 1);
    check("R1 pulses", {prog_req, chip_erase_req, blk_erase_start, suspend_req, resume_req}, 0);
    check("R1 R4 rd_data", rd_data, 0);
  endtask

  task automatic t_ident();
    wr(20'hF5555, 8'hAA); wr(20'hA2AAA, 8'h55); wr(20'h85555, 8'h90);
    check("R2 upper bits ignored", mode, MD_IDENT);
    rd_addr = 20'h00000; #1 check("R4 maker code", rd_data, 8'h20);
    rd_addr = 20'h00001; #1 check("R4 device code", rd_data, 8'hD2);
    rd_addr = 20'h30002; #1 check("R4 protected block", rd_data, 8'h01);
    rd_addr = 20'h20002; #1 check("R4 open block", rd_data, 8'h00);
    rd_addr = 20'h00003; #1 check("R4 reserved", rd_data, 8'h00);
    wr(20'h12345, 8'hF0);
    check("R3 single reset", mode, MD_READ);
    rd_addr = 20'h00000; #1 check("R4 quiet outside ident", rd_data, 8'h00);
    unlock(); wr(20'h05555, 8'h90);
    unlock(); wr(20'h05555, 8'hF0);
    check("R3 three-cycle reset", mode, MD_READ);
  endtask

  task automatic t_abort();
    unlock(); wr(20'h05555, 8'h90);
    wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h00);
    check("R11 bad unlock data", mode, MD_READ);
    wr(20'h05556, 8'hAA); wr(20'h02AAA, 8'h55); wr(20'h05555, 8'h90);
    check("R11 R2 bad coded address", mode, MD_READ);
  endtask

  task automatic t_program();
    unlock(); wr(20'h05555, 8'hA0);
    check("R5 armed no pulse", prog_req, 0);
    wr(20'h31234, 8'h5A);
    check("R5 pulse", prog_req, 1);
    check("R5 addr", prog_addr, 20'h31234);
    check("R5 data", prog_data, 8'h5A);
    check("R5 mode", mode, MD_PROG);
    @(negedge clk);
    check("R5 one cycle", prog_req, 0);
    wr(20'h00000, 8'hF0);
    check("R5 write ignored while busy", mode, MD_PROG);
    done_pulse();
    check("R12 program done", mode, MD_READ);
  endtask

  task automatic t_chip();
    unlock(); wr(20'h05555, 8'h80); unlock(); wr(20'h05555, 8'h10);
    check("R6 pulse", chip_erase_req, 1);
    check("R6 all blocks", erase_set, 16'hFFFF);
    check("R6 mode", mode, MD_ERUN);
    done_pulse();
    check("R12 erase done mode", mode, MD_READ);
    check("R12 set cleared", erase_set, 0);
  endtask

  task automatic t_block_suspend();
    unlock(); wr(20'h05555, 8'h80); unlock(); wr(20'h20000, 8'h30);
    check("R7 window open", erase_win_open, 1);
    check("R7 mode", mode, MD_EWIN);
    repeat (3) @(negedge clk);
    wr(20'h50000, 8'h30);
    check("R8 second block", erase_set, 16'h0024);
    repeat (TO - 1) @(negedge clk);
    check("R8 timer restarted", mode, MD_EWIN);
    check("R7 no early start", blk_erase_start, 0);
    @(negedge clk);
    check("R7 start pulse", blk_erase_start, 1);
    check("R7 running", mode, MD_ERUN);
    check("R7 window closed", erase_win_open, 0);
    wr(20'h99999, 8'hB0);
    check("R9 suspend pulse", suspend_req, 1);
    check("R9 suspended", mode, MD_SUSP);
    unlock(); wr(20'h05555, 8'hA0); wr(20'h20010, 8'h11);
    check("R10 erased block refused", prog_req, 0);
    check("R10 still suspended", mode, MD_SUSP);
    unlock(); wr(20'h05555, 8'hA0); wr(20'h70100, 8'h22);
    check("R10 other block pulse", prog_req, 1);
    check("R10 program in suspend", mode, MD_SPROG);
    done_pulse();
    check("R10 back to suspend", mode, MD_SUSP);
    wr(20'h01234, 8'h30);
    check("R9 resume pulse", resume_req, 1);
    check("R9 resumed", mode, MD_ERUN);
    check("R9 set kept", erase_set, 16'h0024);
    done_pulse();
    check("R12 erase done", erase_set, 0);
  endtask

  task automatic t_window_abort();
    unlock(); wr(20'h05555, 8'h80); unlock(); wr(20'hA0000, 8'h30);
    check("R7 block bit", erase_set, 16'h0400);
    wr(20'hA0000, 8'h55);
    check("R8 abort mode", mode, MD_READ);
    check("R8 abort clears set", erase_set, 0);
    repeat (TO + 2) @(negedge clk);
    check("R8 no start after abort", mode, MD_READ);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_ident();
    t_abort();
    t_program();
    t_chip();
    t_block_suspend();
    t_window_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule